// File: doc/BRIEF.md
# Rolling Three-Row Window Buffer

This block sits between an image source and a 3x3 convolution datapath. A writer streams grayscale rows into it as packed words of several 8-bit pixels. The rows rotate through a ring of four row FIFOs. At any moment three FIFOs hold the rows being convolved and the fourth is free, so the next row can be loaded while the current window pass runs. A finite-state controller reads the three oldest rows in lockstep. It shifts their words into a two-word-wide window per row and raises a window-valid strobe for the downstream multiply-accumulate stage. The start, write-enable and write-data inputs each pass through a two-flop synchronizer before any logic uses them.

The controller has six states. IDLE waits for start. PRIME waits until three complete rows are held. FILL pops the first word of each row into the window. RUN pops the remaining words, one per cycle. ROW_END shifts in a zero word to close the row and releases the oldest FIFO. DONE flushes the ring and returns to IDLE. The transitions are: IDLE->PRIME on synchronized start; PRIME->FILL once three rows are held; FILL->RUN always; RUN->ROW_END after the last word is popped; ROW_END->PRIME while passes remain; ROW_END->DONE after the final pass; DONE->IDLE always. The writer watches `ready`. It may stream one row whenever `ready` is high, and must stop once it drops.

Top module: `rolling_line_buffer`

## Requirements
- R1: During and just after reset, `ready` is high, `mac_en` and `frame_done` are low and `win_data` is all zeros.
- R2: Every input is synchronized by two flops. With three or more complete rows already buffered, a start pulse driven before clock edge 1 gives `mac_en` low after edges 1 to 5 and high after edge 6.
- R3: `ready` is high only while fewer than four complete rows are held and fewer than ROWS rows have been written in the current frame. So at most one new row can be accepted during a window pass.
- R4: A write whose synchronized enable arrives while `ready` is low is dropped and never appears in any window.
- R5: On each `mac_en` cycle of pass p, `win_data` = {top_prev, top_cur, mid_prev, mid_cur, bot_prev, bot_cur}, each one word, most significant first. Top is row p, mid is row p+1 and bot is row p+2. On the i-th window of a pass (i from 0), prev is word i of the row and cur is word i+1. On the last window, cur is zero. Pixel 0 of a word sits in bits [7:0].
- R6: `mac_en` is high for exactly COLS/LANES consecutive cycles per pass, and is low for at least one cycle between passes.
- R7: After start, no window is produced until a third complete row has been written.
- R8: The four FIFOs are reused in rotation. After a pass the oldest FIFO is empty and becomes the write target, so images taller than four rows stream correctly.
- R9: After ROWS-2 passes, `frame_done` is high for one cycle, the ring is emptied and `ready` returns high for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse (asynchronous, synchronized inside) |
| wen | input | 1 | Write enable for one pixel word |
| wdata | input | LANES*PIX_W | Packed pixel word, pixel 0 in the low byte |
| ready | output | 1 | Writer may stream row words |
| mac_en | output | 1 | `win_data` holds a valid window |
| win_data | output | 6*LANES*PIX_W | Three rows of previous and current word, top row first |
| frame_done | output | 1 | One-cycle pulse after the last pass of a frame |

## Verification
Each window is compared against a random image, and the image rows outnumber the ring slots, so any error in role rotation or lane order shows up as a wrong word. The first frame starts with only two rows loaded. This separates correct PRIME gating from a controller that runs on a partial row. The second frame is fully preloaded with four rows and then receives a burst of writes while `ready` is low. That exposes a missing stall or a dropped-write leak, and it also fixes the exact start-to-window latency. Running two frames back to back shows whether DONE really empties the ring.

// File: rtl/rlb_pkg.sv
package rlb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRIME,
        S_FILL,
        S_RUN,
        S_ROW_END,
        S_DONE
    } ctl_state_t;
endpackage

// File: rtl/rlb_sync2.sv
module rlb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rlb_row_fifo.sv
module rlb_row_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    assign rdata = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(DEPTH)))
        else $error("row FIFO overflow");

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0))
        else $error("row FIFO underflow");
endmodule

// File: rtl/rlb_window.sv
module rlb_window #(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift,
    input  logic                  zero_in,
    input  logic                  valid_in,
    input  logic [3*WORD_W-1:0]   din,
    output logic [6*WORD_W-1:0]   win_data,
    output logic                  mac_en
);
    for (genvar r = 0; r < 3; r++) begin : g_row
        logic [WORD_W-1:0] cur_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q  <= '0;
                prev_q <= '0;
            end else if (shift) begin
                cur_q  <= zero_in ? '0 : din[(2-r)*WORD_W +: WORD_W];
                prev_q <= cur_q;
            end
        end

        assign win_data[(5-2*r)*WORD_W +: WORD_W] = prev_q;
        assign win_data[(4-2*r)*WORD_W +: WORD_W] = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mac_en <= 1'b0;
        else        mac_en <= valid_in;
    end
endmodule

// File: rtl/rlb_ctrl.sv
module rlb_ctrl
    import rlb_pkg::*;
#(
    parameter int WPR  = 128,
    parameter int ROWS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rows_ready,
    output logic pop,
    output logic shift,
    output logic zero_in,
    output logic win_valid,
    output logic release_row,
    output logic flush,
    output logic frame_done
);
    localparam int COLW = $clog2(WPR + 1);
    localparam int PCW  = $clog2(ROWS + 1);

    ctl_state_t state, nxt;
    logic [COLW-1:0] col;
    logic [PCW-1:0]  passes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col    <= '0;
            passes <= '0;
        end else begin
            unique case (state)
                S_FILL:    col <= COLW'(1);
                S_RUN:     col <= col + 1'b1;
                S_ROW_END: passes <= passes + 1'b1;
                S_DONE:    passes <= '0;
                default:   col <= col;
            endcase
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_PRIME;
            S_PRIME:   if (rows_ready) nxt = S_FILL;
            S_FILL:    nxt = S_RUN;
            S_RUN:     if (col == COLW'(WPR - 1)) nxt = S_ROW_END;
            S_ROW_END: nxt = (passes == PCW'(ROWS - 3)) ? S_DONE : S_PRIME;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_comb begin
        pop         = 1'b0;
        shift       = 1'b0;
        zero_in     = 1'b0;
        win_valid   = 1'b0;
        release_row = 1'b0;
        flush       = 1'b0;
        frame_done  = 1'b0;
        unique case (state)
            S_IDLE, S_PRIME: ;
            S_FILL: begin
                pop   = 1'b1;
                shift = 1'b1;
            end
            S_RUN: begin
                pop       = 1'b1;
                shift     = 1'b1;
                win_valid = 1'b1;
            end
            S_ROW_END: begin
                shift       = 1'b1;
                zero_in     = 1'b1;
                win_valid   = 1'b1;
                release_row = 1'b1;
            end
            S_DONE: begin
                flush      = 1'b1;
                frame_done = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    prime_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRIME && !rows_ready) |=> (state == S_PRIME))
        else $error("left PRIME without three rows");

    // R6
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ROW_END) |-> ($past(state) == S_RUN))
        else $error("row end not preceded by run");

    // R9
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> (passes == PCW'(ROWS - 2)))
        else $error("frame ended with wrong pass count");
endmodule

// File: rtl/rolling_line_buffer.sv
module rolling_line_buffer #(
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int COLS  = 512,
    parameter int ROWS  = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         wen,
    input  logic [LANES*PIX_W-1:0]       wdata,
    output logic                         ready,
    output logic                         mac_en,
    output logic [6*LANES*PIX_W-1:0]     win_data,
    output logic                         frame_done
);
    localparam int WORD_W = LANES * PIX_W;
    localparam int WPR    = COLS / LANES;
    localparam int NBUF   = 4;
    localparam int PW     = 2;
    localparam int CW     = $clog2(WPR + 1);
    localparam int RW     = $clog2(ROWS + 1);

    logic              start_s, wen_s;
    logic [WORD_W-1:0] wdata_s;

    rlb_sync2 #(.W(1)) i_sync_start (.clk(clk), .rst_n(rst_n), .d(start), .q(start_s));
    rlb_sync2 #(.W(1)) i_sync_wen   (.clk(clk), .rst_n(rst_n), .d(wen),   .q(wen_s));
    rlb_sync2 #(.W(WORD_W)) i_sync_data (.clk(clk), .rst_n(rst_n), .d(wdata), .q(wdata_s));

    logic pop, shift, zero_in, win_valid, release_row, flush;
    logic [RW-1:0] rows_in, rel, held;
    logic [PW-1:0] wsel, base;
    logic          acc_wr, row_done, rows_ready;

    logic [NBUF-1:0]   f_push, f_pop;
    logic [WORD_W-1:0] f_wdata [NBUF];
    logic [WORD_W-1:0] f_rdata [NBUF];
    logic [CW-1:0]     f_count [NBUF];

    assign held       = rows_in - rel;
    assign rows_ready = (held >= RW'(3));
    assign ready      = (rows_in < RW'(ROWS)) && (held < RW'(NBUF));
    assign acc_wr     = wen_s && ready;
    assign row_done   = acc_wr && (f_count[wsel] == CW'(WPR - 1));

    for (genvar g = 0; g < NBUF; g++) begin : g_ring
        logic [PW-1:0] role;
        logic          recirc;

        assign role       = PW'(g) - base;
        assign recirc     = pop && ((role == PW'(1)) || (role == PW'(2)));
        assign f_pop[g]   = pop && (role != PW'(3));
        assign f_push[g]  = recirc || (acc_wr && (wsel == PW'(g)));
        assign f_wdata[g] = recirc ? f_rdata[g] : wdata_s;

        rlb_row_fifo #(.DW(WORD_W), .DEPTH(WPR)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .push  (f_push[g]),
            .wdata (f_wdata[g]),
            .pop   (f_pop[g]),
            .rdata (f_rdata[g]),
            .count (f_count[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_in <= '0;
            rel     <= '0;
            wsel    <= '0;
            base    <= '0;
        end else if (flush) begin
            rows_in <= '0;
            rel     <= '0;
            wsel    <= '0;
            base    <= '0;
        end else begin
            if (row_done) begin
                rows_in <= rows_in + 1'b1;
                wsel    <= wsel + 1'b1;
            end
            if (release_row) begin
                rel  <= rel + 1'b1;
                base <= base + 1'b1;
            end
        end
    end

    rlb_ctrl #(.WPR(WPR), .ROWS(ROWS)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_s),
        .rows_ready  (rows_ready),
        .pop         (pop),
        .shift       (shift),
        .zero_in     (zero_in),
        .win_valid   (win_valid),
        .release_row (release_row),
        .flush       (flush),
        .frame_done  (frame_done)
    );

    rlb_window #(.WORD_W(WORD_W)) i_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (shift),
        .zero_in  (zero_in),
        .valid_in (win_valid),
        .din      ({f_rdata[base], f_rdata[base + PW'(1)], f_rdata[base + PW'(2)]}),
        .win_data (win_data),
        .mac_en   (mac_en)
    );

    // R3
    held_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held <= RW'(NBUF))
        else $error("more rows held than FIFOs");

    // R4
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !flush) |=> (rows_in == $past(rows_in)))
        else $error("row accepted while not ready");

    // R8
    ring_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && pop) |-> (held == RW'(3)))
        else $error("write target overlaps a row being read");
endmodule

// File: tb/test_rolling_line_buffer.sv
module test_rolling_line_buffer;
    localparam int PIX_W = 8;
    localparam int LANES = 4;
    localparam int COLS  = 16;
    localparam int ROWS  = 8;
    localparam int WW    = PIX_W * LANES;
    localparam int WPR   = COLS / LANES;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            wen = 1'b0;
    logic [WW-1:0]   wdata = '0;
    logic            ready, mac_en, frame_done;
    logic [6*WW-1:0] win_data;

    int checks = 0;
    int errors = 0;
    int pass_i = 0;
    int idx = 0;
    int mac_total = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [WW-1:0] img [ROWS][WPR];

    always #2.5 clk = ~clk;

    rolling_line_buffer #(.PIX_W(PIX_W), .LANES(LANES), .COLS(COLS), .ROWS(ROWS)) i_rolling_line_buffer (
        .clk(clk), .rst_n(rst_n), .start(start), .wen(wen), .wdata(wdata),
        .ready(ready), .mac_en(mac_en), .win_data(win_data), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input logic [6*WW-1:0] act, input logic [6*WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [6*WW-1:0] exp_win(input int p, input int i);
        logic [6*WW-1:0] v = '0;
        for (int r = 0; r < 3; r++) begin
            v[(5-2*r)*WW +: WW] = img[p+r][i];
            v[(4-2*r)*WW +: WW] = (i < WPR - 1) ? img[p+r][i+1] : '0;
        end
        return v;
    endfunction

    task automatic new_image();
        for (int r = 0; r < ROWS; r++)
            for (int w = 0; w < WPR; w++)
                img[r][w] = WW'($urandom());
    endtask

    task automatic write_row(input int r);
        while (!ready) @(negedge clk);
        for (int w = 0; w < WPR; w++) begin
            wen   = 1'b1;
            wdata = img[r][w];
            @(negedge clk);
        end
        wen = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Window monitor: R5, R6, R9
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mac_en) begin
                    mac_total++;
                    chk(win_data == exp_win(pass_i, idx), "R5 window content", win_data, exp_win(pass_i, idx));
                    idx++;
                    if (idx == WPR) begin
                        idx = 0;
                        pass_i++;
                    end
                end else if (idx != 0) begin
                    chk(1'b0, "R6 mac_en broke inside a pass", 0, 1);
                    idx = 0;
                end
                if (frame_done) begin
                    chk(pass_i == ROWS - 2, "R9 passes per frame", pass_i, ROWS - 2);
                    pass_i = 0;
                    done_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        new_image();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready in reset", ready, 1);
        chk(mac_en == 1'b0, "R1 mac_en in reset", mac_en, 0);
        chk(frame_done == 1'b0, "R1 frame_done in reset", frame_done, 0);
        chk(win_data == '0, "R1 window in reset", win_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && mac_en == 1'b0, "R1 state after reset", {ready, mac_en}, 2'b10);

        // Frame 1: start with only two rows (R7), then stream the rest (R8 ring wrap)
        write_row(0);
        write_row(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(mac_total == 0, "R7 no window before third row", mac_total, 0);
        for (int r = 2; r < ROWS; r++) write_row(r);
        while (done_cnt < 1) @(negedge clk);
        @(negedge clk);
        chk(frame_done == 1'b0, "R9 frame_done one cycle", frame_done, 0);
        chk(ready == 1'b1, "R9 ready after frame", ready, 1);
        chk(mac_total == (ROWS - 2) * WPR, "R6 window count frame 1", mac_total, (ROWS - 2) * WPR);

        // Frame 2: preload four rows, stall (R3), rejected burst (R4), latency (R2)
        new_image();
        for (int r = 0; r < 4; r++) write_row(r);
        chk(ready == 1'b0, "R3 ready low with four rows held", ready, 0);
        for (int w = 0; w < WPR; w++) begin
            wen   = 1'b1;
            wdata = WW'($urandom());
            @(negedge clk);
        end
        wen = 1'b0;
        repeat (6) @(negedge clk);
        chk(ready == 1'b0, "R3 ready stays low while idle and full", ready, 0);
        start = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            chk(mac_en == 1'b0, "R2 mac_en before edge 6", mac_en, 0);
        end
        @(negedge clk);
        chk(mac_en == 1'b1, "R2 mac_en after edge 6", mac_en, 1);
        for (int r = 4; r < ROWS; r++) write_row(r);
        while (done_cnt < 2) @(negedge clk);
        @(negedge clk);
        chk(frame_done == 1'b0, "R9 frame_done one cycle frame 2", frame_done, 0);
        chk(ready == 1'b1, "R9 ready after frame 2", ready, 1);
        chk(mac_total == 2 * (ROWS - 2) * WPR, "R6 window count frame 2", mac_total, 2 * (ROWS - 2) * WPR);
        summary();
    end
endmodule